// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block keeps four address-window registers that let an address translation unit bypass the page tables. Two windows serve data accesses and two serve instruction fetches. A window covers a region selected by the top byte of a 32-bit logical address. A per-bit mask widens the region, and a privilege field limits which accesses may use it. For each lookup the block takes the logical address, the privilege of the access and a data/instruction select. In the same cycle it reports one of three outcomes: no match, match, or match to a write-protected window.

The windows are loaded in one of two ways. A direct port writes a whole 32-bit word into any one of the four registers. A loader takes a base address and a region size and places a window in a free register of the chosen class. Both kinds of update take effect on the next clock edge. The reset input is asynchronous and active low. It is released to the register bank through a two-stage synchronizer.

Top module: `ttw_matcher`

## Requirements
- R1: While reset is asserted and after it is released, all four registers read as zero, so every lookup returns no match until a register is written.
- R2: `q_result` is 2'b00 for no match, 2'b01 for match and 2'b10 for a write-protected match; 2'b11 never appears.
- R3: A register word holds the window base in bits 31:24, the mask in bits 23:16 and the enable in bit 15. A register matches only if every bit of `q_addr[31:24]` XOR base is zero where the corresponding mask bit is 0; a mask bit of 1 makes that address bit a don't-care.
- R4: Bit 14 of a register word means "any privilege". When bit 14 is 0, `q_super` must equal bit 13 (1 = supervisor-only, 0 = user-only), or that register does not match.
- R5: A register with bit 2 (write-protect) set that matches gives 2'b10. Bits 12:3 and 1:0 are stored but have no effect on the result.
- R6: With `q_data`=1 only registers 2 and 3 (data class) are consulted; with `q_data`=0 only registers 0 and 1 (instruction class) are consulted.
- R7: Within the selected class, the lower-numbered register decides the result when it matches. The higher one is consulted only when the lower one does not match, including when the lower one fails on privilege.
- R8: A loader request for class `ld_data` writes the class's upper register if its enable is clear. Otherwise it writes the lower register if that enable is clear. When both are enabled the request changes nothing.
- R9: The word the loader writes has base = `ld_base[31:24]`, mask = (`ld_base`+`ld_size`-1)[31:24] and enable = 1, with all other bits 0. The loaded window is therefore user-only and not write-protected.
- R10: `wr_en` writes `wr_data` to register `wr_sel` (index = 2·class + position, class 1 = data), visible to lookups from the next cycle. When `wr_en` and `ld_en` are both high in one cycle, the loader request is ignored.
- R11: A register whose enable bit is 0 never matches, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Direct register write strobe |
| wr_sel | input | 2 | Register index for the direct write |
| wr_data | input | 32 | Word written by the direct write |
| ld_en | input | 1 | Loader request strobe |
| ld_data | input | 1 | Loader class: 1 data, 0 instruction |
| ld_base | input | 32 | Region base address for the loader |
| ld_size | input | 32 | Region size in bytes for the loader |
| q_addr | input | 32 | Logical address to look up |
| q_super | input | 1 | Access privilege: 1 supervisor, 0 user |
| q_data | input | 1 | Access class: 1 data, 0 instruction |
| q_result | output | 2 | Lookup outcome code |

## Verification
The hardest case to reach from the ports is one where the lower register of a class covers the address but fails only on privilege, while the upper register covers the same address and is write-protected. This is the only situation in which the fall-through order decides between two live windows. The stimulus builds it with direct writes of hand-made words, then looks the address up with both privileges. The loader's "both busy" case is reached the same way: two loader calls fill the class, a third is issued, and the earlier lookups are repeated. A long random phase then biases addresses onto a few window bases so that overlaps and masks occur often, and a per-cycle behavioural model checks each result.

// File: rtl/ttw_pkg.sv
package ttw_pkg;

  typedef enum logic [1:0] {
    TTW_NONE   = 2'b00,
    TTW_HIT    = 2'b01,
    TTW_HIT_WP = 2'b10
  } ttw_res_e;

  // field positions inside a window word
  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int ANY_BIT  = 14;
  localparam int SUP_BIT  = 13;
  localparam int WP_BIT   = 2;

endpackage

// File: rtl/ttw_rst_sync.sv
module ttw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/ttw_window_cmp.sv
module ttw_window_cmp
  import ttw_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int FIELD_W = 8
) (
  input  logic [REG_W-1:0]   cfg,
  input  logic [FIELD_W-1:0] addr_hi,
  input  logic               is_super,
  output ttw_res_e           res
);
  logic [FIELD_W-1:0] diff;
  logic               priv_ok;
  logic               hit;

  always_comb begin
    diff    = (addr_hi ^ cfg[BASE_LSB +: FIELD_W]) & ~cfg[MASK_LSB +: FIELD_W];
    priv_ok = cfg[ANY_BIT] | (cfg[SUP_BIT] == is_super);
    hit     = cfg[EN_BIT] & (diff == '0) & priv_ok;
    if (!hit)             res = TTW_NONE;
    else if (cfg[WP_BIT]) res = TTW_HIT_WP;
    else                  res = TTW_HIT;
  end
endmodule

// File: rtl/ttw_reg_bank.sv
module ttw_reg_bank
  import ttw_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 32,
  parameter int FIELD_W = 8,
  parameter int NREG    = 4,
  localparam int SEL_W  = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n_i,
  input  logic                      wr_en,
  input  logic [SEL_W-1:0]          wr_sel,
  input  logic [REG_W-1:0]          wr_data,
  input  logic                      ld_en,
  input  logic                      ld_data,
  input  logic [ADDR_W-1:0]         ld_base,
  input  logic [ADDR_W-1:0]         ld_size,
  output logic [NREG-1:0][REG_W-1:0] cfg
);
  logic [NREG-1:0][REG_W-1:0] cfg_nxt;
  logic [ADDR_W-1:0]          ld_last;
  logic [REG_W-1:0]           ld_word;
  logic [SEL_W-1:0]           idx_hi;
  logic [SEL_W-1:0]           idx_lo;
  logic                       upd;

  assign idx_hi = {ld_data, 1'b1};
  assign idx_lo = {ld_data, 1'b0};
  assign upd    = wr_en | ld_en;

  always_comb begin
    ld_last                       = ld_base + ld_size - 1'b1;
    ld_word                       = '0;
    ld_word[BASE_LSB +: FIELD_W]  = ld_base[ADDR_W-1 -: FIELD_W];
    ld_word[MASK_LSB +: FIELD_W]  = ld_last[ADDR_W-1 -: FIELD_W];
    ld_word[EN_BIT]               = 1'b1;

    cfg_nxt = cfg;
    if (wr_en) begin
      cfg_nxt[wr_sel] = wr_data;
    end else if (ld_en) begin
      if (!cfg[idx_hi][EN_BIT])      cfg_nxt[idx_hi] = ld_word;
      else if (!cfg[idx_lo][EN_BIT]) cfg_nxt[idx_lo] = ld_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)  cfg <= '0;
    else if (upd)  cfg <= cfg_nxt;
  end

  // R1: held clear through reset
  a_r1_clear_in_reset: assert property (@(posedge clk)
    !rst_n_i |=> cfg == '0);

  // R10: a direct write lands in the selected register
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_en |=> cfg[$past(wr_sel)] == $past(wr_data));

  // R8: loader with both registers of the class busy changes nothing
  a_r8_busy_no_change: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ld_en && !wr_en && cfg[idx_hi][EN_BIT] && cfg[idx_lo][EN_BIT]) |=> $stable(cfg));

  // R8: free upper register is the one that gets enabled
  a_r8_upper_first: assert property (@(posedge clk) disable iff (!rst_n_i)
    (ld_en && !wr_en && !cfg[idx_hi][EN_BIT]) |=> cfg[$past(idx_hi)][EN_BIT]);
endmodule

// File: rtl/ttw_matcher.sv
module ttw_matcher
  import ttw_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int REG_W   = 32,
  parameter int FIELD_W = 8,
  localparam int PER_CLASS = 2,
  localparam int NREG      = 2 * PER_CLASS,
  localparam int SEL_W     = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              ld_en,
  input  logic              ld_data,
  input  logic [ADDR_W-1:0] ld_base,
  input  logic [ADDR_W-1:0] ld_size,
  input  logic [ADDR_W-1:0] q_addr,
  input  logic              q_super,
  input  logic              q_data,
  output logic [1:0]        q_result
);
  logic                        rst_n_i;
  logic [NREG-1:0][REG_W-1:0]  cfg;
  ttw_res_e                    slot_res [PER_CLASS];
  ttw_res_e                    sel_res;

  ttw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  ttw_reg_bank #(
    .REG_W   (REG_W),
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W),
    .NREG    (NREG)
  ) u_bank (
    .clk     (clk),
    .rst_n_i (rst_n_i),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .ld_en   (ld_en),
    .ld_data (ld_data),
    .ld_base (ld_base),
    .ld_size (ld_size),
    .cfg     (cfg)
  );

  for (genvar g = 0; g < PER_CLASS; g++) begin : g_slot
    ttw_window_cmp #(
      .REG_W   (REG_W),
      .FIELD_W (FIELD_W)
    ) u_cmp (
      .cfg      (cfg[q_data * PER_CLASS + g]),
      .addr_hi  (q_addr[ADDR_W-1 -: FIELD_W]),
      .is_super (q_super),
      .res      (slot_res[g])
    );
  end

  // lower slot wins; later slots consulted only on a miss
  always_comb begin
    sel_res = TTW_NONE;
    for (int k = PER_CLASS - 1; k >= 0; k--) begin
      if (slot_res[k] != TTW_NONE) sel_res = slot_res[k];
    end
  end

  assign q_result = sel_res;

  // R2: code 2'b11 is never produced
  a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(q_result));

  // R11: a class with both windows disabled never matches
  a_r11_idle_class: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cfg[q_data * PER_CLASS][EN_BIT] && !cfg[q_data * PER_CLASS + 1][EN_BIT])
      |-> q_result == TTW_NONE);
endmodule

// File: tb/ttw_matcher_bench.sv
module ttw_matcher_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        ld_en = 1'b0;
  logic        ld_data = 1'b0;
  logic [31:0] ld_base = '0;
  logic [31:0] ld_size = '0;
  logic [31:0] q_addr = '0;
  logic        q_super = 1'b0;
  logic        q_data = 1'b0;
  logic [1:0]  q_result;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_tag = "R1";
  logic [31:0] mregs [4];

  always #4 clk = ~clk;

  ttw_matcher u_ttw_matcher (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ld_en(ld_en), .ld_data(ld_data), .ld_base(ld_base), .ld_size(ld_size),
    .q_addr(q_addr), .q_super(q_super), .q_data(q_data), .q_result(q_result)
  );

  // behavioural reference state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) mregs[i] = 32'h0;
    end else if (wr_en) begin
      mregs[wr_sel] = wr_data;
    end else if (ld_en) begin
      logic [31:0] w;
      logic [31:0] last;
      last = ld_base + ld_size - 32'd1;
      w = {ld_base[31:24], last[31:24], 16'h8000};
      if (!mregs[ld_data * 2 + 1][15])  mregs[ld_data * 2 + 1] = w;
      else if (!mregs[ld_data * 2][15]) mregs[ld_data * 2] = w;
    end
  end

  function automatic logic [1:0] expect_of(logic [31:0] a, logic s, logic d);
    for (int k = 0; k < 2; k++) begin
      logic [31:0] w;
      w = mregs[d * 2 + k];
      if (w[15] && (((a[31:24] ^ w[31:24]) & ~w[23:16]) == 8'h00) && (w[14] || (w[13] == s)))
        return w[2] ? 2'b10 : 2'b01;
    end
    return 2'b00;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [1:0] exp;
    exp = expect_of(q_addr, q_super, q_data);
    n_cmp++;
    if (q_result !== exp) begin
      n_bad++;
      $display("FAIL %s: addr=%h super=%0b data=%0b got %b expected %b",
               cur_tag, q_addr, q_super, q_data, q_result, exp);
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    ld_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] idx, input logic [31:0] d, input string tag);
    cur_tag = tag; wr_sel = idx; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic ld(input logic cls, input logic [31:0] b, input logic [31:0] sz, input string tag);
    cur_tag = tag; ld_data = cls; ld_base = b; ld_size = sz; ld_en = 1'b1;
    @(posedge clk); #1; ld_en = 1'b0;
  endtask

  task automatic q(input logic [31:0] a, input logic s, input logic d, input string tag);
    cur_tag = tag; q_addr = a; q_super = s; q_data = d;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    cur_tag = "R1";
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
  endtask

  initial begin
    #1;
    do_reset();
    // R1: nothing matches after reset
    q(32'h0000_0000, 1'b0, 1'b0, "R1");
    q(32'hFF00_0000, 1'b1, 1'b1, "R1");

    // R3: base 0x40, mask 0x0F, any privilege
    wr(2'd2, 32'h400F_C000, "R3");
    q(32'h4A00_0000, 1'b0, 1'b1, "R3");
    q(32'h5000_0000, 1'b0, 1'b1, "R3");
    q(32'h4F12_3456, 1'b1, 1'b1, "R3");
    // R7: upper data window supervisor-only, write-protected
    wr(2'd3, 32'h4000_A004, "R7");
    q(32'h4000_0000, 1'b1, 1'b1, "R7");
    // R4 / R5: lower window now user-only, supervisor falls through
    wr(2'd2, 32'h400F_8000, "R4");
    q(32'h4000_0000, 1'b1, 1'b1, "R5");
    q(32'h4000_0000, 1'b0, 1'b1, "R4");
    q(32'h4100_0000, 1'b1, 1'b1, "R4");
    q(32'h4100_0000, 1'b0, 1'b1, "R4");
    // R6: instruction class is independent
    q(32'h4000_0000, 1'b0, 1'b0, "R6");
    wr(2'd0, 32'h40FF_C000, "R6");
    q(32'h9000_0000, 1'b1, 1'b0, "R6");
    q(32'h9000_0000, 1'b1, 1'b1, "R6");
    // R11: fields set but enable clear
    wr(2'd0, 32'h90FF_4004, "R11");
    wr(2'd1, 32'h9000_6004, "R11");
    q(32'h9000_0000, 1'b1, 1'b0, "R11");
    q(32'h9000_0000, 1'b0, 1'b0, "R11");

    // R8 / R9: loader fills upper then lower, then nothing
    ld(1'b0, 32'h1000_0000, 32'h0300_0000, "R8");
    q(32'h1000_0000, 1'b0, 1'b0, "R9");
    q(32'h1200_0000, 1'b0, 1'b0, "R9");
    q(32'h1100_0000, 1'b0, 1'b0, "R9");
    q(32'h1000_0000, 1'b1, 1'b0, "R9");
    ld(1'b0, 32'h8000_0000, 32'h0100_0000, "R8");
    q(32'h8000_0000, 1'b0, 1'b0, "R8");
    q(32'h0000_0000, 1'b0, 1'b0, "R8");
    ld(1'b0, 32'h3000_0000, 32'h0000_1000, "R8");
    q(32'h3000_0000, 1'b0, 1'b0, "R8");
    q(32'h8000_0000, 1'b0, 1'b0, "R8");
    q(32'h1000_0000, 1'b0, 1'b0, "R8");

    // R10: write and loader together, loader ignored
    wr(2'd3, 32'h0, "R10");
    cur_tag = "R10";
    wr_sel = 2'd2; wr_data = 32'h0; wr_en = 1'b1;
    ld_data = 1'b1; ld_base = 32'h2000_0000; ld_size = 32'h0100_0000; ld_en = 1'b1;
    tick();
    q(32'h2000_0000, 1'b0, 1'b1, "R10");
    q(32'h2000_0000, 1'b1, 1'b1, "R10");

    // R2: random mix with addresses biased onto a few bases
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      r = $urandom;
      cur_tag = "R2";
      case (r[2:0])
        3'd0: begin
          wr_sel = r[4:3];
          wr_data = {r[7:5], 5'h0, 4'h0, r[11:8], r[15:13], 10'h0, r[16], 2'h0} | {$urandom} & 32'h0000_1FFB;
          wr_en = 1'b1;
        end
        3'd1: begin
          ld_data = r[3]; ld_base = {r[6:4], 29'h0} | ($urandom & 32'h1FFF_FFFF);
          ld_size = $urandom & 32'h0FFF_FFFF; ld_en = 1'b1;
        end
        default: ;
      endcase
      q_addr  = {r[20:18], 5'h0, 24'h0} | ($urandom & (r[21] ? 32'hFFFF_FFFF : 32'h1FFF_FFFF));
      q_super = r[22];
      q_data  = r[23];
      tick();
    end

    // R1: reset in mid-run clears all windows
    do_reset();
    q(32'h4000_0000, 1'b1, 1'b1, "R1");
    q(32'h1000_0000, 1'b0, 1'b0, "R1");
    q(32'h8000_0000, 1'b0, 1'b0, "R1");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer than 100000", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule